// File: doc/BRIEF.md
# Clock PLL Bring-Up Sequencer

This block brings a pair of receive PLLs and a pair of transmit PLLs from an unknown state to running, by editing a 32-bit clock-control register through a simple write port. A single start pulse launches the sequence. The block captures the register's present contents and the configuration inputs, then issues four writes on consecutive cycles. The first write forces every PLL into powerdown and bypass. The second programs the clock-mode and multiplier fields. The third releases bypass. The fourth removes powerdown.

Each direction runs in dual-clock mode whenever its width-mode field is nonzero. In that mode the second PLL of the direction is released and powered together with the first. The lock indicators of the PLLs are not reliable. For that reason the block does not read them: it waits a fixed settle time, derived from the clock rate, and then raises done. Done stays high until the next accepted start.

Top module: `pll_bringup_seq`

## Requirements
- R1: A direction is in dual mode exactly when its width-mode input is nonzero. The mode is sampled on the cycle the start pulse is accepted.
- R2: The first write carries the captured register value (`cur_value` on the accepting cycle) with bits 4–7 and 12–15 forced to 1.
- R3: In the second write, bit 24 equals the receive dual flag and bit 25 equals the transmit dual flag.
- R4: The second write places the multipliers sampled at start as follows: rx pair 0/1 at bits 17:16, rx pair 2/3 at bits 19:18, tx pair 0/1 at bits 21:20, tx pair 2/3 at bits 23:22. All other bits are unchanged from the first write.
- R5: The third write clears bits 12 and 14 of the second write's value. It also clears bit 13 when receive is dual and bit 15 when transmit is dual. All other bits are unchanged.
- R6: The fourth write clears bits 4 and 6 of the third write's value. It also clears bit 5 when receive is dual and bit 7 when transmit is dual. All other bits are unchanged.
- R7: The four writes occupy four consecutive cycles, with `wr_en` high for exactly one cycle each and `wr_addr` equal to the CTRL_ADDR parameter. The first write is seen one cycle after the start pulse is sampled. `wr_en` is never high while the block is not busy.
- R8: `done` rises SETTLE_US×CLK_MHZ cycles after the edge that issued the fourth write, and `busy` falls at the same edge. `done` then stays high until the next accepted start, and `done` and `busy` are never high together.
- R9: A start pulse that arrives while `busy` is high has no effect on the write sequence, its values or its timing.
- R10: While reset is held, and on the first cycle after reset, `wr_en`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| rx_width | input | WMODE_W | Receive width-mode field (0 = single 32-bit lane) |
| tx_width | input | WMODE_W | Transmit width-mode field (0 = single 32-bit lane) |
| rx_mul01 | input | 2 | Multiplier for receive PLL pair 0/1 |
| rx_mul23 | input | 2 | Multiplier for receive PLL pair 2/3 |
| tx_mul01 | input | 2 | Multiplier for transmit PLL pair 0/1 |
| tx_mul23 | input | 2 | Multiplier for transmit PLL pair 2/3 |
| cur_value | input | 32 | Present clock-control register contents, sampled on the accepting cycle |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | AW | Register address of the write |
| wr_data | output | 32 | Data of the write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished and settled |

## Verification
A corrupted working value shows up on `wr_data` at the very next strobe. Because every step edits the previous step's value, an error made in one step is carried visibly into every later write of the same run. A wrong step state or a miscounted settle timer shows as a strobe on the wrong cycle, or as `done` rising one or more cycles off the expected edge. Comparing every cycle against the model therefore exposes such faults within the same sequence. Starts injected during the write burst and during the settle wait show whether the captured configuration or the timing has been disturbed.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int REG_W = 32;
  localparam int MUL_W = 2;

  localparam logic [REG_W-1:0] FORCE_OFF_MASK = 32'h0000_F0F0;
  localparam logic [REG_W-1:0] CFG_FIELD_MASK = 32'h03FF_0000;
  localparam logic [REG_W-1:0] BYP_BASE_MASK  = 32'h0000_5000;
  localparam logic [REG_W-1:0] PD_BASE_MASK   = 32'h0000_0050;

  typedef enum logic [1:0] {
    STEP_FORCE_OFF,
    STEP_CONFIG,
    STEP_RELEASE,
    STEP_POWER_ON
  } step_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONFIG,
    ST_RELEASE,
    ST_POWER,
    ST_SETTLE
  } seq_state_e;
endpackage

// File: rtl/pll_dual_detect.sv
module pll_dual_detect #(
  parameter int W = 2
) (
  input  logic [W-1:0] mode,
  output logic         dual
);
  assign dual = |mode;
endmodule

// File: rtl/pll_step_alu.sv
module pll_step_alu
  import pll_seq_pkg::*;
#(
  parameter int NMUL = 4
) (
  input  step_e                  step,
  input  logic [REG_W-1:0]       base,
  input  logic [1:0]             dual,
  input  logic [NMUL*MUL_W-1:0]  mul,
  output logic [REG_W-1:0]       result
);
  always_comb begin
    result = base;
    unique case (step)
      STEP_FORCE_OFF: result = base | FORCE_OFF_MASK;
      STEP_CONFIG: begin
        result = base & ~CFG_FIELD_MASK;
        result[16 +: NMUL*MUL_W] = mul;
        result[24] = dual[0];
        result[25] = dual[1];
      end
      STEP_RELEASE: begin
        result = base & ~BYP_BASE_MASK;
        if (dual[0]) result[13] = 1'b0;
        if (dual[1]) result[15] = 1'b0;
      end
      STEP_POWER_ON: begin
        result = base & ~PD_BASE_MASK;
        if (dual[0]) result[5] = 1'b0;
        if (dual[1]) result[7] = 1'b0;
      end
      default: result = base;
    endcase
  end
endmodule

// File: rtl/pll_settle_timer.sv
module pll_settle_timer #(
  parameter int CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);

  p_cnt_range_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_cnt_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> cnt_q == '0);
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int              WMODE_W   = 2,
  parameter int              AW        = 8,
  parameter logic [AW-1:0]   CTRL_ADDR = '0,
  parameter int              CLK_MHZ   = 100,
  parameter int              SETTLE_US = 100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WMODE_W-1:0] rx_width,
  input  logic [WMODE_W-1:0] tx_width,
  input  logic [1:0]         rx_mul01,
  input  logic [1:0]         rx_mul23,
  input  logic [1:0]         tx_mul01,
  input  logic [1:0]         tx_mul23,
  input  logic [31:0]        cur_value,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [31:0]        wr_data,
  output logic               busy,
  output logic               done
);
  localparam int NMUL       = 4;
  localparam int MULS_W     = NMUL * MUL_W;
  localparam int SETTLE_CYC = (CLK_MHZ * SETTLE_US > 0) ? CLK_MHZ * SETTLE_US : 1;

  seq_state_e        state_q;
  logic [REG_W-1:0]  work_q;
  logic [1:0]        dual_q;
  logic [MULS_W-1:0] mul_q;

  logic [1:0]        dual_in;
  logic [MULS_W-1:0] mul_in;
  logic              accept;
  step_e             step;
  logic [REG_W-1:0]  alu_base;
  logic [1:0]        alu_dual;
  logic [MULS_W-1:0] alu_mul;
  logic [REG_W-1:0]  next_val;
  logic              settle_hit;

  pll_dual_detect #(.W(WMODE_W)) u_rx_mode (.mode(rx_width), .dual(dual_in[0]));
  pll_dual_detect #(.W(WMODE_W)) u_tx_mode (.mode(tx_width), .dual(dual_in[1]));

  assign mul_in = {tx_mul23, tx_mul01, rx_mul23, rx_mul01};
  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_CONFIG:  step = STEP_CONFIG;
      ST_RELEASE: step = STEP_RELEASE;
      ST_POWER:   step = STEP_POWER_ON;
      default:    step = STEP_FORCE_OFF;
    endcase
  end

  assign alu_base = accept ? cur_value : work_q;
  assign alu_dual = accept ? dual_in   : dual_q;
  assign alu_mul  = accept ? mul_in    : mul_q;

  pll_step_alu #(.NMUL(NMUL)) u_alu (
    .step  (step),
    .base  (alu_base),
    .dual  (alu_dual),
    .mul   (alu_mul),
    .result(next_val)
  );

  pll_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (state_q == ST_SETTLE),
    .expired(settle_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      work_q  <= '0;
      dual_q  <= '0;
      mul_q   <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            dual_q  <= dual_in;
            mul_q   <= mul_in;
            work_q  <= next_val;
            wr_data <= next_val;
            wr_en   <= 1'b1;
            busy    <= 1'b1;
            done    <= 1'b0;
            state_q <= ST_CONFIG;
          end
        end
        ST_CONFIG, ST_RELEASE, ST_POWER: begin
          work_q  <= next_val;
          wr_data <= next_val;
          wr_en   <= 1'b1;
          state_q <= (state_q == ST_CONFIG)  ? ST_RELEASE :
                     (state_q == ST_RELEASE) ? ST_POWER : ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_hit) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_addr = CTRL_ADDR;

  // R2: first write of a run has all powerdown and bypass bits set
  p_force_off_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wr_en && ((wr_data & FORCE_OFF_MASK) == FORCE_OFF_MASK));
  // R3 / R4: second write carries the captured mode flags and multipliers
  p_config_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && !$past(wr_en, 2)) |->
      (wr_data[23:16] == mul_q) && (wr_data[25:24] == dual_q));
  // R5: third write has the bypass bits released
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en, 2) && !$past(wr_en, 3)) |->
      !wr_data[12] && !wr_data[14] &&
      !(dual_q[0] && wr_data[13]) && !(dual_q[1] && wr_data[15]));
  // R7: strobes only while busy
  p_write_busy_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);
  // R8: done and busy exclusive
  p_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  // R9: captured configuration untouched during a run
  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mul_q) && $stable(dual_q));
endmodule

// File: tb/tb_pll_bringup_seq.sv
`timescale 1ns/1ps
module tb_pll_bringup_seq;
  localparam int CLK_MHZ   = 2;
  localparam int SETTLE_US = 5;
  localparam int NSET      = CLK_MHZ * SETTLE_US;
  localparam logic [7:0] ADDR = 8'h3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] rx_width = '0, tx_width = '0;
  logic [1:0] rx_mul01 = '0, rx_mul23 = '0, tx_mul01 = '0, tx_mul23 = '0;
  logic [31:0] cur_value = '0;
  logic wr_en, busy, done;
  logic [7:0] wr_addr;
  logic [31:0] wr_data;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pll_bringup_seq #(.WMODE_W(2), .AW(8), .CTRL_ADDR(ADDR),
                    .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US)) dut (
    .clk(clk), .rst(rst), .start(start), .rx_width(rx_width), .tx_width(tx_width),
    .rx_mul01(rx_mul01), .rx_mul23(rx_mul23), .tx_mul01(tx_mul01), .tx_mul23(tx_mul23),
    .cur_value(cur_value), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done));

  // behavioural reference model
  int          m_ph = 0;
  int          m_cnt = 0;
  int          m_step = 0;
  bit          m_rxd, m_txd;
  bit [1:0]    m_r01, m_r23, m_t01, m_t23;
  bit [31:0]   m_v = 0;
  bit          e_en = 0, e_busy = 0, e_done = 0;
  bit [31:0]   e_data = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; e_en = 0; e_busy = 0; e_done = 0; m_step = 0;
    end else begin
      e_en = 0;
      case (m_ph)
        0: if (start) begin
          m_rxd = (rx_width != 0); m_txd = (tx_width != 0);
          m_r01 = rx_mul01; m_r23 = rx_mul23; m_t01 = tx_mul01; m_t23 = tx_mul23;
          m_v = cur_value | 32'h0000F0F0;
          e_en = 1; e_data = m_v; e_busy = 1; e_done = 0; m_step = 1; m_ph = 2;
        end
        2: begin
          m_v = m_v & ~32'h03FF0000;
          m_v = m_v | (32'(m_txd) << 25) | (32'(m_rxd) << 24) | (32'(m_t23) << 22)
                    | (32'(m_t01) << 20) | (32'(m_r23) << 18) | (32'(m_r01) << 16);
          e_en = 1; e_data = m_v; m_step = 2; m_ph = 3;
        end
        3: begin
          m_v = m_v & ~(32'h5000 | (32'(m_rxd) << 13) | (32'(m_txd) << 15));
          e_en = 1; e_data = m_v; m_step = 3; m_ph = 4;
        end
        4: begin
          m_v = m_v & ~(32'h50 | (32'(m_rxd) << 5) | (32'(m_txd) << 7));
          e_en = 1; e_data = m_v; m_step = 4; m_ph = 5; m_cnt = 0;
        end
        5: begin
          if (m_cnt == NSET - 1) begin
            e_done = 1; e_busy = 0; m_ph = 0;
          end else m_cnt++;
        end
        default: m_ph = 0;
      endcase
    end
  end

  function automatic string data_tag(int st, logic [31:0] a, logic [31:0] e);
    if (st == 1) return "R2";
    if (st == 2) return (a[25:24] != e[25:24]) ? "R1/R3" : "R4";
    if (st == 3) return "R5";
    return "R6";
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    tests++;
    if (wr_en !== e_en || (e_en && wr_addr !== ADDR)) begin
      fails++;
      $display("FAIL R7: wr_en=%0b addr=%h expected wr_en=%0b addr=%h", wr_en, wr_addr, e_en, ADDR);
    end else if (e_en && wr_data !== e_data) begin
      fails++;
      $display("FAIL %s: wr_data=%h expected %h", data_tag(m_step, wr_data, e_data), wr_data, e_data);
    end else if (busy !== e_busy || done !== e_done) begin
      fails++;
      $display("FAIL %s: busy=%0b done=%0b expected busy=%0b done=%0b",
               rst ? "R10" : "R8", busy, done, e_busy, e_done);
    end
  end

  task automatic check(bit cond, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(logic [1:0] rw, logic [1:0] tw, logic [7:0] m, logic [31:0] cv);
    @(negedge clk);
    rx_width = rw; tx_width = tw;
    {tx_mul23, tx_mul01, rx_mul23, rx_mul01} = m;
    cur_value = cv; start = 1;
    @(negedge clk);
    start = 0;
    rx_width = ~rw; tx_mul01 = ~m[5:4]; cur_value = ~cv;   // must not matter after capture
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cycles(3);
    // R10: reset state
    check(wr_en === 0 && busy === 0 && done === 0, "R10", {29'b0, wr_en, busy, done}, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(wr_en === 0 && busy === 0 && done === 0, "R10", {29'b0, wr_en, busy, done}, 0);

    // single/single, all zeros initial value
    launch(2'b00, 2'b00, 8'hE4, 32'h0);
    check(wr_en === 1 && wr_data[31:0] === 32'h0000F0F0, "R2", wr_data, 32'h0000F0F0);
    wait_cycles(NSET + 6);
    check(done === 1, "R8", {31'b0, done}, 1);
    wait_cycles(5);
    check(done === 1 && busy === 0, "R8", {30'b0, done, busy}, 2);

    // dual rx only, all-ones initial value (R1 via bits 24/13/5)
    launch(2'b10, 2'b00, 8'h1B, 32'hFFFF_FFFF);
    wait_cycles(NSET + 6);

    // dual tx only, with starts during write burst and settle (R9)
    launch(2'b00, 2'b01, 8'h93, 32'hA5A5_5A5A);
    start = 1; rx_mul01 = 2'b11; @(negedge clk); start = 0;
    check(busy === 1, "R9", {31'b0, busy}, 1);
    wait_cycles(5);
    start = 1; @(negedge clk); start = 0;
    check(busy === 1 && wr_en === 0, "R9", {30'b0, busy, wr_en}, 2);
    wait_cycles(NSET + 4);

    // both dual, restart straight after done
    launch(2'b11, 2'b11, 8'h6C, 32'h1234_0F0F);
    wait_cycles(NSET + 4);
    launch(2'b01, 2'b10, 8'hFF, 32'hFC00_0000);
    wait_cycles(NSET + 6);

    // reset during settle
    launch(2'b11, 2'b00, 8'h55, 32'h0);
    wait_cycles(6);
    rst = 1; @(negedge clk); @(negedge clk);
    check(busy === 0 && done === 0 && wr_en === 0, "R10", {29'b0, wr_en, busy, done}, 0);
    rst = 0;
    launch(2'b00, 2'b11, 8'hA0, 32'h8000_0001);
    wait_cycles(NSET + 6);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule